// File: doc/BRIEF.md
# DRAM Strobe Sequencer

This block drives the three control strobes of an asynchronous DRAM access. While idle it samples a request line on every clock edge. When it sees the request high, it runs a fixed four-cycle access and then returns to idle. During the access it first pulls the row strobe low. One cycle later it switches the address multiplexer to the column address. One cycle after that it pulls the column strobe low. At the end it releases all three together.

Each strobe is a flip-flop output. Its value is decoded from the state the machine is about to enter, so it changes on the same clock edge as the state register. The pins therefore never see a combinational glitch, and the registers add no cycle of latency. The address and data paths, refresh and device timing belong to the surrounding logic.

Top module: `dram_strobe_seq`

## Requirements
- R1: While the synchronous active-low reset is sampled low, the machine goes to idle. On the edge after that, row_stb_n_o is 1, addr_mux_o is 0 and col_stb_n_o is 1.
- R2: In idle, with req_i sampled low, all three outputs keep their idle values (1, 0, 1).
- R3: In idle, req_i sampled high at an edge starts an access. Right after that same edge row_stb_n_o is 0, addr_mux_o is 0 and col_stb_n_o is 1.
- R4: Once an access has started, row_stb_n_o stays low for exactly four clock cycles and then returns high.
- R5: addr_mux_o is 1 in the second, third and fourth cycles of an access, and 0 at all other times.
- R6: col_stb_n_o is 0 in the third and fourth cycles of an access, and 1 at all other times.
- R7: A request sampled during an access has no effect on the sequence. The machine always spends at least one cycle in idle between accesses, so a request held high continuously gives one access every five cycles.
- R8: The strobes are nested: col_stb_n_o low implies addr_mux_o high, and addr_mux_o high implies row_stb_n_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Access request, sampled only while idle |
| row_stb_n_o | output | 1 | Row strobe, active low, registered |
| addr_mux_o | output | 1 | Address multiplexer select (1 = column address), registered |
| col_stb_n_o | output | 1 | Column strobe, active low, registered |

## Verification
The bench holds the request low for a long stretch, which shows that idle is stable. It then gives isolated one-cycle pulses, which expose the exact cycle each strobe moves relative to the sampling edge. A request held high continuously shows the forced idle cycle between accesses. Request pulses placed at every phase of a running access separate a machine that ignores them from one that restarts or stretches the access. A reset in the middle of an access checks that the strobes fall back to idle at once.

// File: rtl/dram_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding and strobe bundle for the DRAM strobe sequencer.
// Assumes a binary state code; the values 0..4 give the order of the access.
package dram_seq_pkg;
    localparam int SEQ_STATE_W = 4;

    typedef enum logic [SEQ_STATE_W-1:0] {
        ST_IDLE = 4'd0,
        ST_ROW  = 4'd1,
        ST_MUX  = 4'd2,
        ST_COL  = 4'd3,
        ST_HOLD = 4'd4
    } seq_state_e;

    typedef struct packed {
        logic row_n;
        logic amux;
        logic col_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{row_n: 1'b1, amux: 1'b0, col_n: 1'b1};
endpackage

// File: rtl/dram_seq_next.sv
`timescale 1ns/1ps
// Module: next-state logic of the sequencer.
// Samples the request only while idle. Walks the four access states in fixed
// order, one per cycle. Any encoding outside 0..4 is sent back to idle.
module dram_seq_next
    import dram_seq_pkg::*;
(
    input  seq_state_e state_i,
    input  logic       req_i,
    output seq_state_e next_o
);
    // Purpose: choose the state for the next edge.
    always_comb begin
        case (state_i)
            ST_IDLE: next_o = req_i ? ST_ROW : ST_IDLE;
            ST_ROW:  next_o = ST_MUX;
            ST_MUX:  next_o = ST_COL;
            ST_COL:  next_o = ST_HOLD;
            ST_HOLD: next_o = ST_IDLE;
            default: next_o = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/dram_seq_outreg.sv
`timescale 1ns/1ps
// Module: registered strobe decode.
// Decodes the strobes from the next-state value and stores them in flip-flops,
// so the pins move on the same edge as the state and never glitch.
// Assumes a synchronous active-low reset.
module dram_seq_outreg
    import dram_seq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_n,
    input  seq_state_e next_i,
    output strobe_t    strobe_o
);
    strobe_t strobe_d;

    // Purpose: decode the strobe levels that belong to the coming state.
    always_comb begin
        strobe_d       = STROBE_IDLE;
        strobe_d.row_n = (next_i == ST_IDLE);
        strobe_d.amux  = (next_i == ST_MUX) || (next_i == ST_COL) || (next_i == ST_HOLD);
        strobe_d.col_n = !((next_i == ST_COL) || (next_i == ST_HOLD));
    end

    // Purpose: hold the strobes in flip-flops, idle levels under reset.
    always_ff @(posedge clk_i) begin
        if (!rst_n) strobe_o <= STROBE_IDLE;
        else        strobe_o <= strobe_d;
    end

    // R8
    col_in_mux_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        !strobe_o.col_n |-> strobe_o.amux);
    // R8
    mux_in_row_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        strobe_o.amux |-> !strobe_o.row_n);
endmodule

// File: rtl/dram_strobe_seq.sv
`timescale 1ns/1ps
// Module: top of the DRAM strobe sequencer.
// Holds the state register and joins the next-state logic to the registered
// strobe decode. Assumes req_i is synchronous to clk_i.
module dram_strobe_seq
    import dram_seq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_n,
    input  logic req_i,
    output logic row_stb_n_o,
    output logic addr_mux_o,
    output logic col_stb_n_o
);
    seq_state_e state_q;
    seq_state_e state_d;
    strobe_t    strobe;

    dram_seq_next u_next (
        .state_i (state_q),
        .req_i   (req_i),
        .next_o  (state_d)
    );

    dram_seq_outreg u_outreg (
        .clk_i    (clk_i),
        .rst_n    (rst_n),
        .next_i   (state_d),
        .strobe_o (strobe)
    );

    // Purpose: state register, forced to idle under reset.
    always_ff @(posedge clk_i) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign row_stb_n_o = strobe.row_n;
    assign addr_mux_o  = strobe.amux;
    assign col_stb_n_o = strobe.col_n;

    // R1
    reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        $past(!rst_n) |-> (row_stb_n_o && !addr_mux_o && col_stb_n_o));
    // R3
    start_row_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        (state_q == ST_IDLE && req_i) |=> (!row_stb_n_o && !addr_mux_o && col_stb_n_o));
    // R7
    start_only_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        $fell(row_stb_n_o) |-> $past(state_q == ST_IDLE && req_i));
    // R5
    mux_after_row_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        $rose(addr_mux_o) |-> $past(!row_stb_n_o));
    // R6
    col_two_cycles_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        (!col_stb_n_o && $past(!col_stb_n_o)) |=> col_stb_n_o);
endmodule

// File: tb/dram_strobe_seq_bench.sv
`timescale 1ns/1ps
module dram_strobe_seq_bench;
    typedef struct {
        logic  row_n;
        logic  amux;
        logic  col_n;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic row_n, amux, col_n;

    exp_t exp_q[$];
    int checks = 0;
    int fails = 0;
    int model = 0;
    bit done = 1'b0;
    int low_run = 0;
    bit run_clean = 1'b1;

    always #10 clk = ~clk;

    dram_strobe_seq u_dram_strobe_seq (
        .clk_i       (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .row_stb_n_o (row_n),
        .addr_mux_o  (amux),
        .col_stb_n_o (col_n)
    );

    // Driver: apply one cycle of input and queue the expected outputs.
    task automatic step(input logic r, input logic rs);
        int nm;
        exp_t e;
        @(negedge clk);
        rst_n = rs;
        req = r;
        if (!rs)             nm = 0;
        else if (model == 0) nm = r ? 1 : 0;
        else if (model == 4) nm = 0;
        else                 nm = model + 1;
        e.row_n = (nm == 0);
        e.amux  = (nm >= 2);
        e.col_n = !(nm >= 3);
        if (!rs)                   e.tag = "R1";
        else if (model == 0 && !r) e.tag = "R2";
        else if (model == 0)       e.tag = "R3";
        else if (r)                e.tag = "R7";
        else if (nm == 2)          e.tag = "R5";
        else if (nm >= 3)          e.tag = "R6";
        else                       e.tag = "R4";
        exp_q.push_back(e);
        model = nm;
    endtask

    // Monitor: compare the queued expectations with the outputs.
    always @(posedge clk) begin
        #5;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (row_n !== e.row_n || amux !== e.amux || col_n !== e.col_n) begin
                fails++;
                $display("FAIL %s: got row_n=%b amux=%b col_n=%b expected %b %b %b",
                         e.tag, row_n, amux, col_n, e.row_n, e.amux, e.col_n);
            end
            // R8 nesting of the strobes
            checks++;
            if ((!col_n && !amux) || (amux && row_n)) begin
                fails++;
                $display("FAIL R8: got row_n=%b amux=%b col_n=%b expected nested strobes",
                         row_n, amux, col_n);
            end
            // R4 row strobe low run length
            if (!rst_n) run_clean = 1'b0;
            if (!row_n) low_run++;
            else begin
                if (low_run != 0 && run_clean) begin
                    checks++;
                    if (low_run != 4) begin
                        fails++;
                        $display("FAIL R4: got row strobe low for %0d cycles expected 4", low_run);
                    end
                end
                low_run = 0;
                run_clean = 1'b1;
            end
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0);      // R1 under reset, req ignored
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1);      // R2 idle
        step(1'b1, 1'b1);                                   // R3 single pulse
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1);
        for (int i = 0; i < 15; i++) step(1'b1, 1'b1);     // R7 held request
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
        for (int p = 1; p <= 4; p++) begin                  // R7 pulse at each phase
            step(1'b1, 1'b1);
            for (int k = 1; k < p; k++) step(1'b0, 1'b1);
            step(1'b1, 1'b1);
            for (int k = 0; k < 6; k++) step(1'b0, 1'b1);
        end
        step(1'b1, 1'b1);                                   // R1 reset mid-access
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1);
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R1: got %0d unchecked items expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got no completion expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule